// File: doc/BRIEF.md
# T1 Framing-Loss Monitor and Search Trigger

This block sits behind a T1 receive framer that has already locked onto the frame. On every framing-bit slot it compares the received framing bit with the value the framer expects. It keeps a short history of mismatches. When two mismatches fall inside a sliding window of recent framing bits, it flags loss of frame. The window length is chosen at run time and can be four, five or six framing bits.

The block also decides when the external pattern searcher must start a new frame hunt. Three things can start a hunt:
- a loss of frame, which triggers automatically;
- the onset of receive carrier loss, which triggers automatically unless carrier-loss triggering is masked;
- a host command, which fires on the rising edge of a control bit.

A single control bit turns off both automatic triggers. Every hunt request is a one-cycle pulse. The status stays at out-of-frame until the searcher reports that it has found alignment again.

Top module: `t1_oof_resync`

## Requirements
- R1: With `win_six`=0 and `win_five`=0, `frame_lost` goes to 1 once 2 of the last 4 checked framing bits were errors. Two errors that are 4 checked bits apart do not set it.
- R2: With `win_six`=0 and `win_five`=1, the window is the last 5 checked framing bits. Two errors that are 4 checked bits apart set `frame_lost`. Two errors that are 5 apart do not.
- R3: With `win_six`=1, the window is the last 6 checked framing bits, whatever `win_five` is. Two errors 5 apart set `frame_lost`. Two errors 6 apart do not.
- R4: A checked framing bit is an error when `fbit_rx` differs from `fbit_exp` in a cycle where `fbit_stb`=1. `frame_lost` rises in the cycle after the strobe that carries the second error in the window.
- R5: With `auto_off`=0, a loss of frame raises `search_start` in the same cycle that `frame_lost` rises.
- R6: With `auto_off`=0 and `loss_ignore`=0, a 0-to-1 change of `carrier_loss` gives a `search_start` pulse in the next cycle. With `loss_ignore`=1 it gives none.
- R7: With `auto_off`=1, neither a loss of frame nor a carrier-loss onset produces `search_start`. A loss of frame still sets `frame_lost`.
- R8: A 0-to-1 change of `host_search` gives a `search_start` pulse in the next cycle, whatever `auto_off` is. Holding `host_search` at 1 gives no further pulse.
- R9: Starting a hunt sets `frame_lost` to 1 and clears the error history. Strobes are not recorded while `frame_lost`=1. `frame_lost` returns to 0 only in the cycle after `search_done`=1.
- R10: Triggers that coincide produce a single `search_start` pulse that lasts one cycle.
- R11: While `rst`=1, `frame_lost`=1 and `search_start`=0. In the first cycle after `rst` falls, `search_start` pulses once to request the initial hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fbit_stb | input | 1 | A framing-bit slot is present this cycle |
| fbit_exp | input | 1 | Framing-bit value the framer expects |
| fbit_rx | input | 1 | Framing-bit value received |
| carrier_loss | input | 1 | Receive carrier-loss level |
| win_five | input | 1 | Selects the 5-bit window when `win_six`=0 |
| win_six | input | 1 | Selects the 6-bit window, overriding `win_five` |
| loss_ignore | input | 1 | Stops carrier-loss onset from triggering a hunt |
| auto_off | input | 1 | Turns off all automatic hunt triggers |
| host_search | input | 1 | Host hunt command, acts on its rising edge |
| search_done | input | 1 | Searcher reports alignment found |
| frame_lost | output | 1 | Out-of-frame status (registered) |
| search_start | output | 1 | One-cycle hunt request (registered) |

## Verification
The bench places error pairs exactly at the window edge for each window length. A design that counts one bit too many or too few would flag, or miss, a pair that is 4, 5 or 6 bits apart. It sends error strobes while the block is out of frame and then one error after realignment. A design that kept recording history during the hunt, or that did not clear it, would flag loss early. It holds `host_search` and `carrier_loss` high over several cycles, and fires a loss of frame, a host edge and a carrier-loss edge in the same cycle. A level-sensitive trigger or a stretched request would show up as extra or longer `search_start` pulses. It also tries carrier-loss onsets with the mask set and with automatic triggering off. A design that ignored either control would produce a pulse there.

// File: rtl/t1_oof_pkg.sv
package t1_oof_pkg;

  // Run-time window choice for the error history.
  typedef enum logic [1:0] {
    WIN_SHORT = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LONG  = 2'd2
  } win_e;

  // Sources that may ask for a new frame hunt in one cycle.
  typedef struct packed {
    logic boot;   // first cycle after reset
    logic host;   // host command edge
    logic frame;  // automatic, framing loss
    logic loss;   // automatic, carrier-loss onset
  } trig_t;

  // The long-window select has priority over the mid-window select.
  function automatic win_e decode_win(input logic sel_long, input logic sel_mid);
    if (sel_long)     return WIN_LONG;
    else if (sel_mid) return WIN_MID;
    else              return WIN_SHORT;
  endfunction

  function automatic int win_len(input win_e w, input int short_len,
                                 input int mid_len, input int long_len);
    case (w)
      WIN_LONG: return long_len;
      WIN_MID:  return mid_len;
      default:  return short_len;
    endcase
  endfunction

endpackage

// File: rtl/oof_rise_det.sv
module oof_rise_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_VAL;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R8: a held level yields one event only
  p_single_edge_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/oof_err_window.sv
module oof_err_window
  import t1_oof_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int MID_LEN   = 5,
  parameter int LONG_LEN  = 6,
  parameter int ERR_LIMIT = 2,
  localparam int HIST_W   = LONG_LEN,
  localparam int CNT_W    = $clog2(HIST_W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic err,
  input  logic arm,    // in frame: record strobes
  input  logic clr,    // a hunt starts: forget history
  input  win_e win,
  output logic hit     // loss-of-frame detection this cycle
);

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] hist_next;
  logic [HIST_W-1:0] mask;
  logic [CNT_W-1:0]  cnt;
  int                len;

  assign len       = win_len(win, SHORT_LEN, MID_LEN, LONG_LEN);
  assign hist_next = {hist[HIST_W-2:0], err};

  // Position 0 holds the newest bit; keep positions inside the window.
  for (genvar i = 0; i < HIST_W; i++) begin : g_mask
    assign mask[i] = (i < len);
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < HIST_W; k++) begin
      cnt = cnt + CNT_W'(hist_next[k] & mask[k]);
    end
  end

  assign hit = stb & arm & (cnt >= CNT_W'(ERR_LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)      hist <= '0;
    else if (stb && arm) hist <= hist_next;
  end

  // R9: a hunt wipes the history
  p_clear_hist_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hist == '0));

  // R9: nothing is recorded while out of frame
  p_frozen_hist_r9: assert property (@(posedge clk) disable iff (rst)
    (!arm && !clr) |=> $stable(hist));

  // R4: only strobes move the history
  p_idle_hist_r4: assert property (@(posedge clk) disable iff (rst)
    (!stb && !clr) |=> $stable(hist));

endmodule

// File: rtl/oof_search_ctl.sv
module oof_search_ctl
  import t1_oof_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_hit,
  input  logic loss_rise,
  input  logic host_rise,
  input  logic found,
  input  logic loss_ignore,
  input  logic auto_off,
  output logic start_now,
  output logic frame_lost,
  output logic search_start
);

  logic  boot_q;
  trig_t trig;

  always_comb begin
    trig.boot  = boot_q;
    trig.host  = host_rise;
    trig.frame = ~auto_off & frame_hit;
    trig.loss  = ~auto_off & ~loss_ignore & loss_rise;
  end

  // Any source collapses into one request.
  assign start_now = |trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q       <= 1'b1;
      frame_lost   <= 1'b1;
      search_start <= 1'b0;
    end else begin
      boot_q       <= 1'b0;
      search_start <= start_now;
      if (start_now || frame_hit) frame_lost <= 1'b1;
      else if (found)             frame_lost <= 1'b0;
    end
  end

  // R9: a request always coincides with out-of-frame status
  p_start_marks_lost_r9: assert property (@(posedge clk) disable iff (rst)
    search_start |-> frame_lost);

  // R7: automatic sources are silent when turned off
  p_auto_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (auto_off && !host_rise && !boot_q) |=> !search_start);

  // R9: alignment report restores in-frame status
  p_found_restores_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_lost && found && !start_now) |=> !frame_lost);

  // R5: framing loss with automatic mode raises a request
  p_frame_trig_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_hit && !auto_off) |=> (search_start && frame_lost));

endmodule

// File: rtl/t1_oof_resync.sv
module t1_oof_resync
  import t1_oof_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int MID_LEN   = 5,
  parameter int LONG_LEN  = 6,
  parameter int ERR_LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fbit_stb,
  input  logic fbit_exp,
  input  logic fbit_rx,
  input  logic carrier_loss,
  input  logic win_five,
  input  logic win_six,
  input  logic loss_ignore,
  input  logic auto_off,
  input  logic host_search,
  input  logic search_done,
  output logic frame_lost,
  output logic search_start
);

  localparam int N_EDGE = 2;

  logic [N_EDGE-1:0] lvl_vec;
  logic [N_EDGE-1:0] rise_vec;
  logic              frame_hit;
  logic              start_now;
  win_e              win;

  assign lvl_vec = {host_search, carrier_loss};
  assign win     = decode_win(win_six, win_five);

  // One edge detector per level-style trigger.
  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    oof_rise_det #(.RST_VAL(1'b1)) u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl_vec[e]),
      .rise (rise_vec[e])
    );
  end

  oof_err_window #(
    .SHORT_LEN (SHORT_LEN),
    .MID_LEN   (MID_LEN),
    .LONG_LEN  (LONG_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_window (
    .clk (clk),
    .rst (rst),
    .stb (fbit_stb),
    .err (fbit_rx ^ fbit_exp),
    .arm (~frame_lost),
    .clr (start_now),
    .win (win),
    .hit (frame_hit)
  );

  oof_search_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .frame_hit    (frame_hit),
    .loss_rise    (rise_vec[0]),
    .host_rise    (rise_vec[1]),
    .found        (search_done),
    .loss_ignore  (loss_ignore),
    .auto_off     (auto_off),
    .start_now    (start_now),
    .frame_lost   (frame_lost),
    .search_start (search_start)
  );

  // R11: reset holds out-of-frame with no request
  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> (frame_lost && !search_start));

  // R8: a host edge is served even with automatic mode off
  p_host_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (host_search && !$past(host_search) && !$past(rst)) |=> search_start);

endmodule

// File: tb/t1_oof_resync_bench.sv
module t1_oof_resync_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fbit_stb = 0, fbit_exp = 0, fbit_rx = 0, carrier_loss = 0;
  logic win_five = 0, win_six = 0, loss_ignore = 0, auto_off = 0;
  logic host_search = 0, search_done = 0;
  logic frame_lost, search_start;

  always #10 clk = ~clk;  // 50 MHz

  t1_oof_resync u_t1_oof_resync (
    .clk(clk), .rst(rst), .fbit_stb(fbit_stb), .fbit_exp(fbit_exp),
    .fbit_rx(fbit_rx), .carrier_loss(carrier_loss), .win_five(win_five),
    .win_six(win_six), .loss_ignore(loss_ignore), .auto_off(auto_off),
    .host_search(host_search), .search_done(search_done),
    .frame_lost(frame_lost), .search_start(search_start)
  );

  typedef struct {
    int    cyc;
    logic  lost;
    logic  start;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic exp_bit = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop the item due this cycle and compare.
  always @(negedge clk) begin : mon
    exp_t it;
    if (q.size() > 0 && q[0].cyc == cyc) begin
      it = q.pop_front();
      n_checks++;
      if (frame_lost !== it.lost || search_start !== it.start) begin
        n_fail++;
        $display("FAIL %s: frame_lost=%0b search_start=%0b expected %0b/%0b",
                 it.tag, frame_lost, search_start, it.lost, it.start);
      end
    end
  end

  task automatic push_next(input logic lost, input logic start, input string tag);
    exp_t it;
    it.cyc = cyc + 1; it.lost = lost; it.start = start; it.tag = tag;
    q.push_back(it);
  endtask

  // Driver: one cycle of stimulus plus the result expected after the edge.
  task automatic step(input logic stb, input logic err, input logic loss,
                      input logic host, input logic done,
                      input logic elost, input logic estart, input string tag);
    @(negedge clk);
    fbit_stb = stb;
    if (stb) begin
      exp_bit  = ~exp_bit;
      fbit_exp = exp_bit;
      fbit_rx  = exp_bit ^ err;
    end
    carrier_loss = loss;
    host_search  = host;
    search_done  = done;
    push_next(elost, estart, tag);
  endtask

  task automatic fb(input logic err, input logic elost, input logic estart,
                    input string tag);
    step(1'b1, err, carrier_loss, host_search, 1'b0, elost, estart, tag);
  endtask

  task automatic cfg(input logic five, input logic six, input logic lign,
                     input logic aoff);
    @(negedge clk);
    fbit_stb = 0; search_done = 0;
    win_five = five; win_six = six; loss_ignore = lign; auto_off = aoff;
  endtask

  task automatic direct(input logic lost, input logic start, input string tag);
    n_checks++;
    if (frame_lost !== lost || search_start !== start) begin
      n_fail++;
      $display("FAIL %s: frame_lost=%0b search_start=%0b expected %0b/%0b",
               tag, frame_lost, search_start, lost, start);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct(1'b1, 1'b0, "R11 reset state");
    rst = 1'b0;
    push_next(1'b1, 1'b1, "R11 initial hunt pulse");
    step(0, 0, 0, 0, 0, 1, 0, "R11 pulse is one cycle");
    fb(1, 1, 0, "R9 strobe ignored while hunting");
    step(0, 0, 0, 0, 1, 0, 0, "R9 found restores in-frame");

    // Window of 4, automatic off
    cfg(0, 0, 0, 1);
    fb(1, 0, 0, "R1 first error");
    fb(0, 0, 0, "R1"); fb(0, 0, 0, "R1"); fb(0, 0, 0, "R1");
    fb(1, 0, 0, "R1 errors 4 apart do not flag");
    fb(0, 0, 0, "R1"); fb(0, 0, 0, "R1");
    fb(1, 1, 0, "R1 R4 R7 two in four flags, no auto pulse");
    step(0, 0, 0, 0, 0, 1, 0, "R7 still lost, no pulse");
    step(0, 0, 0, 1, 0, 1, 1, "R8 host edge pulses with auto off");
    step(0, 0, 0, 1, 0, 1, 0, "R8 held host gives no pulse");
    step(0, 0, 0, 1, 1, 0, 0, "R9 found while host held");
    step(0, 0, 0, 0, 0, 0, 0, "R8 host fall is silent");
    step(0, 0, 0, 1, 0, 1, 1, "R8 second rise pulses again");
    step(0, 0, 0, 0, 1, 0, 0, "R9 realign");

    // Window of 5, automatic on
    cfg(1, 0, 0, 0);
    fb(1, 0, 0, "R2");
    fb(0, 0, 0, "R2"); fb(0, 0, 0, "R2"); fb(0, 0, 0, "R2"); fb(0, 0, 0, "R2");
    fb(1, 0, 0, "R2 errors 5 apart do not flag");
    fb(0, 0, 0, "R2"); fb(0, 0, 0, "R2"); fb(0, 0, 0, "R2");
    fb(1, 1, 1, "R2 R5 two in five flags with auto pulse");
    step(0, 0, 0, 0, 0, 1, 0, "R5 pulse lasts one cycle");
    step(0, 0, 0, 0, 1, 0, 0, "R9 realign");

    // Window of 6, mid select also set
    cfg(1, 1, 0, 0);
    fb(1, 0, 0, "R3");
    fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3");
    fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3");
    fb(1, 0, 0, "R3 errors 6 apart do not flag");
    fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3"); fb(0, 0, 0, "R3");
    fb(1, 1, 1, "R3 two in six flags, mid select ignored");
    fb(1, 1, 0, "R9 error strobe during hunt ignored");
    fb(1, 1, 0, "R9 error strobe during hunt ignored");
    step(0, 0, 0, 0, 1, 0, 0, "R9 realign");
    fb(1, 0, 0, "R9 history was cleared");

    // Coincident triggers: framing loss, host edge and carrier onset
    step(1, 1, 1, 1, 0, 1, 1, "R10 coincident triggers give one pulse");
    step(0, 0, 1, 1, 0, 1, 0, "R10 no second pulse");
    step(0, 0, 0, 0, 1, 0, 0, "R9 realign");

    // Carrier loss gating
    step(0, 0, 1, 0, 0, 1, 1, "R6 carrier onset pulses");
    step(0, 0, 1, 0, 0, 1, 0, "R6 held carrier loss silent");
    step(0, 0, 0, 0, 1, 0, 0, "R9 realign");
    cfg(1, 1, 1, 0);
    step(0, 0, 1, 0, 0, 0, 0, "R6 masked carrier onset ignored");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    cfg(1, 1, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0, "R7 carrier onset ignored with auto off");
    step(0, 0, 0, 0, 0, 0, 0, "R7");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule